// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This block erases one block of a parallel NOR flash. It drives the device command bus and reads the device status register. When an erase request arrives while the block is idle, it issues a status clear, the erase setup and the erase confirm to the block address. It then polls until the device reports that it is ready. After that it switches the device back to status mode, reads the final status and maps it to one error code. If the status shows any error bit, it clears the device status. An erase that fails on its own is restarted automatically, up to a fixed number of extra attempts.

While the erase is being polled, a suspend request makes the block pause the erase, so that the host can use the device for something else. The block acknowledges through `susp_o`. A resume request continues the erase. A suspend that the device does not acknowledge in time is undone and flagged with an error. The erase itself keeps going. A poll that runs past its tick budget ends the operation with a timeout code.

Top module: `flash_erase_ctrl`

## Requirements
- R1: Out of reset: `busy_o`, `susp_o` and `done_o` are 0, `err_o` is 0 (none), and the block drives no flash write or read. No flash access happens while `busy_o` is 0.
- R2: A request on `erase_req_i` while idle is accepted. `err_o` clears to 0, and on consecutive cycles the block writes 0x50, 0x20 and 0xD0 to the latched block address. A request while busy is ignored. Every write uses the latched address.
- R3: After the confirm, the block asserts `flash_rd_o` each cycle until status bit 7 reads 1.
- R4: When the erase completes, the block writes 0x70 and then reads status. If the status AND 0x3A is nonzero, it next writes 0x50 and then 0x70.
- R5: The error code is chosen by priority. Bits 4 and 5 both set gives 1 (command sequence). Otherwise bit 1 gives 2 (protected). Otherwise bit 3 gives 3 (low voltage). Otherwise bit 5 gives 4 (erase failure). Otherwise the code is 0.
- R6: Code 4 starts the full erase sequence again, for at most 3 extra attempts (4 attempts in total) before 4 is reported. A later attempt that succeeds reports 0.
- R7: If status bit 7 does not set within ERASE_TO_TICKS × TICK_CYC polling cycles (default 80), the operation ends with code 5 (timeout).
- R8: `suspend_req_i` is acted on only while the erase is being polled. The block then writes 0xB0 and then 0x70, and polls until bit 7 reads 1, after which `susp_o` is 1. While suspended there is no flash access. A suspend request when idle does nothing.
- R9: If the suspend poll exceeds SUSP_TO_TICKS × TICK_CYC cycles (default 8), the block writes 0xD0 and then 0x70 and resumes polling the erase. `err_o` becomes 6 at once. The final code is 6 unless completion decodes a nonzero code.
- R10: `resume_req_i` is acted on only while suspended. The block writes 0xD0 and then 0x70 and returns to polling with a fresh timeout budget. A resume request at any other time does nothing.
- R11: `done_o` is a single-cycle pulse that coincides with `busy_o` falling. `err_o` holds its value until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| erase_req_i | input | 1 | Start an erase of `blk_addr_i` |
| blk_addr_i | input | AW | Block address, latched on accept |
| suspend_req_i | input | 1 | Request to suspend the running erase |
| resume_req_i | input | 1 | Request to resume a suspended erase |
| flash_status_i | input | 8 | Device status byte, valid in read cycles |
| flash_wr_o | output | 1 | Command write strobe |
| flash_rd_o | output | 1 | Status read strobe |
| flash_addr_o | output | AW | Address for command write and status read |
| flash_data_o | output | 8 | Command byte |
| busy_o | output | 1 | Operation in progress |
| susp_o | output | 1 | Erase suspended |
| done_o | output | 1 | Completion pulse |
| err_o | output | 3 | Error code (see R5, R7, R9) |

## Verification
The assertions assume the host behaves sensibly. It does not raise `resume_req_i` in the same cycle as the suspend acknowledge, and requests are synchronous single-cycle or held levels. The bench drives every request at the falling edge and holds `suspend_req_i` only until it sees the acknowledge or the suspend error. The bench's flash model freezes the erase countdown while a suspend is pending or active, and it returns status bit 7 only after the modelled latency. Because of this, every suspend, resume and completion path is reached through the device response alone, and never by timing coincidence.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  localparam logic [7:0] CMD_CLR_STAT = 8'h50;
  localparam logic [7:0] CMD_SETUP    = 8'h20;
  localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND  = 8'hB0;
  localparam logic [7:0] CMD_RD_STAT  = 8'h70;
  localparam logic [7:0] STAT_ERR_MSK = 8'h3A;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_SEQ     = 3'd1,
    ERR_PROT    = 3'd2,
    ERR_VLOW    = 3'd3,
    ERR_ERASE   = 3'd4,
    ERR_TIMEOUT = 3'd5,
    ERR_SUSP    = 3'd6
  } err_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CLR, ST_SETUP, ST_CONF, ST_POLL,
    ST_SB0, ST_S70, ST_SPOLL, ST_SUSP,
    ST_RD0, ST_R70, ST_FIN, ST_CHK, ST_CLR2, ST_ST70
  } st_e;

endpackage

// File: rtl/flash_erase_timer.sv
module flash_erase_timer #(
  parameter int unsigned TICK_CYC = 4,
  parameter int unsigned TK_W     = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  input  logic            run_i,
  input  logic [TK_W-1:0] limit_i,
  output logic            expired_o
);

  logic [TK_W-1:0] tick_q;
  logic            tick_adv;

  assign expired_o = (tick_q >= limit_i);

  generate
    if (TICK_CYC > 1) begin : g_prescale
      localparam int unsigned PRE_W = $clog2(TICK_CYC);
      logic [PRE_W-1:0] pre_q;
      assign tick_adv = run_i && !expired_o && (pre_q == PRE_W'(TICK_CYC - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                    pre_q <= '0;
        else if (restart_i || tick_adv) pre_q <= '0;
        else if (run_i && !expired_o)   pre_q <= pre_q + 1'b1;
      end
    end else begin : g_direct
      assign tick_adv = run_i && !expired_o;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tick_q <= '0;
    else if (restart_i) tick_q <= '0;
    else if (tick_adv)  tick_q <= tick_q + 1'b1;
  end

endmodule

// File: rtl/flash_erase_decode.sv
module flash_erase_decode
  import flash_erase_pkg::*;
(
  input  logic [7:0] status_i,
  output err_e       code_o,
  output logic       clear_o
);

  assign clear_o = |(status_i & STAT_ERR_MSK);

  always_comb begin
    if (status_i[4] && status_i[5]) code_o = ERR_SEQ;
    else if (status_i[1])           code_o = ERR_PROT;
    else if (status_i[3])           code_o = ERR_VLOW;
    else if (status_i[5])           code_o = ERR_ERASE;
    else                            code_o = ERR_NONE;
  end

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import flash_erase_pkg::*;
#(
  parameter int unsigned AW             = 16,
  parameter int unsigned TICK_CYC       = 4,
  parameter int unsigned ERASE_TO_TICKS = 20,
  parameter int unsigned SUSP_TO_TICKS  = 2,
  parameter int unsigned MAX_RETRY      = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          erase_req_i,
  input  logic [AW-1:0] blk_addr_i,
  input  logic          suspend_req_i,
  input  logic          resume_req_i,
  input  logic [7:0]    flash_status_i,
  output logic          flash_wr_o,
  output logic          flash_rd_o,
  output logic [AW-1:0] flash_addr_o,
  output logic [7:0]    flash_data_o,
  output logic          busy_o,
  output logic          susp_o,
  output logic          done_o,
  output logic [2:0]    err_o
);

  localparam int unsigned MAX_TO = (ERASE_TO_TICKS > SUSP_TO_TICKS) ? ERASE_TO_TICKS : SUSP_TO_TICKS;
  localparam int unsigned TK_W   = $clog2(MAX_TO + 1);
  localparam int unsigned RT_W   = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;

  st_e             st_q;
  logic [AW-1:0]   addr_q;
  err_e            err_q, dec_q, dec_code, final_code;
  logic [RT_W-1:0] retry_q;
  logic            sfail_q, done_q;
  logic            dec_clear, t_restart, t_run, t_expired;
  logic [TK_W-1:0] t_limit;
  logic            unused_status;

  assign unused_status = ^{flash_status_i[6], flash_status_i[0]};

  flash_erase_decode u_decode (
    .status_i (flash_status_i),
    .code_o   (dec_code),
    .clear_o  (dec_clear)
  );

  assign t_restart = (st_q == ST_CONF) || (st_q == ST_S70) || (st_q == ST_R70);
  assign t_run     = (st_q == ST_POLL) || (st_q == ST_SPOLL);
  assign t_limit   = (st_q == ST_SPOLL) ? TK_W'(SUSP_TO_TICKS) : TK_W'(ERASE_TO_TICKS);

  flash_erase_timer #(.TICK_CYC(TICK_CYC), .TK_W(TK_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (t_restart),
    .run_i     (t_run),
    .limit_i   (t_limit),
    .expired_o (t_expired)
  );

  // command bus decode
  always_comb begin
    flash_wr_o   = 1'b1;
    flash_data_o = CMD_RD_STAT;
    unique case (st_q)
      ST_CLR, ST_CLR2: flash_data_o = CMD_CLR_STAT;
      ST_SETUP:        flash_data_o = CMD_SETUP;
      ST_CONF, ST_RD0: flash_data_o = CMD_CONFIRM;
      ST_SB0:          flash_data_o = CMD_SUSPEND;
      ST_S70, ST_R70, ST_FIN, ST_ST70: flash_data_o = CMD_RD_STAT;
      default:         flash_wr_o = 1'b0;
    endcase
  end

  assign flash_rd_o   = (st_q == ST_POLL) || (st_q == ST_SPOLL) || (st_q == ST_CHK);
  assign flash_addr_o = addr_q;
  assign busy_o       = (st_q != ST_IDLE);
  assign susp_o       = (st_q == ST_SUSP);
  assign done_o       = done_q;
  assign err_o        = err_q;

  // decoded error wins; otherwise an earlier suspend failure stays visible
  assign final_code = (dec_q != ERR_NONE) ? dec_q : (sfail_q ? ERR_SUSP : ERR_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      err_q   <= ERR_NONE;
      dec_q   <= ERR_NONE;
      retry_q <= '0;
      sfail_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (erase_req_i) begin
          st_q    <= ST_CLR;
          addr_q  <= blk_addr_i;
          err_q   <= ERR_NONE;
          dec_q   <= ERR_NONE;
          retry_q <= '0;
          sfail_q <= 1'b0;
        end
        ST_CLR:   st_q <= ST_SETUP;
        ST_SETUP: st_q <= ST_CONF;
        ST_CONF:  st_q <= ST_POLL;
        ST_POLL: begin
          if (flash_status_i[7])  st_q <= ST_FIN;
          else if (suspend_req_i) st_q <= ST_SB0;
          else if (t_expired) begin
            st_q   <= ST_IDLE;
            err_q  <= ERR_TIMEOUT;
            done_q <= 1'b1;
          end
        end
        ST_SB0: st_q <= ST_S70;
        ST_S70: st_q <= ST_SPOLL;
        ST_SPOLL: begin
          if (flash_status_i[7]) st_q <= ST_SUSP;
          else if (t_expired) begin
            st_q    <= ST_RD0;
            sfail_q <= 1'b1;
            err_q   <= ERR_SUSP;
          end
        end
        ST_SUSP: if (resume_req_i) st_q <= ST_RD0;
        ST_RD0:  st_q <= ST_R70;
        ST_R70:  st_q <= ST_POLL;
        ST_FIN:  st_q <= ST_CHK;
        ST_CHK: begin
          dec_q <= dec_code;
          if (dec_clear) st_q <= ST_CLR2;
          else begin
            st_q   <= ST_IDLE;
            err_q  <= sfail_q ? ERR_SUSP : ERR_NONE;
            done_q <= 1'b1;
          end
        end
        ST_CLR2: st_q <= ST_ST70;
        ST_ST70: begin
          if (dec_q == ERR_ERASE && retry_q < RT_W'(MAX_RETRY)) begin
            st_q    <= ST_CLR;
            retry_q <= retry_q + 1'b1;
            dec_q   <= ERR_NONE;
          end else begin
            st_q   <= ST_IDLE;
            err_q  <= final_code;
            done_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_erase_chk.sv
module flash_erase_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       erase_req_i,
  input logic       resume_req_i,
  input logic       flash_wr_o,
  input logic       flash_rd_o,
  input logic [7:0] flash_data_o,
  input logic       busy_o,
  input logic       susp_o,
  input logic       done_o,
  input logic [2:0] err_o
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !flash_wr_o && !flash_rd_o);

  // R2
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && erase_req_i |=> busy_o && flash_wr_o && flash_data_o == 8'h50 && err_o == 3'd0);

  // R2
  setup_confirm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_wr_o && flash_data_o == 8'h20 |=> flash_wr_o && flash_data_o == 8'hD0);

  // R8
  susp_cmd_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_wr_o && flash_data_o == 8'hB0 |=> flash_wr_o && flash_data_o == 8'h70);

  // R8
  susp_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_o |-> busy_o && !flash_wr_o && !flash_rd_o);

  // R10
  resume_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_o && resume_req_i |=> !susp_o && flash_wr_o && flash_data_o == 8'hD0);

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R11
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !erase_req_i |=> $stable(err_o));

endmodule

bind flash_erase_ctrl flash_erase_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .erase_req_i  (erase_req_i),
  .resume_req_i (resume_req_i),
  .flash_wr_o   (flash_wr_o),
  .flash_rd_o   (flash_rd_o),
  .flash_data_o (flash_data_o),
  .busy_o       (busy_o),
  .susp_o       (susp_o),
  .done_o       (done_o),
  .err_o        (err_o)
);

// File: tb/flash_erase_ctrl_test.sv
`timescale 1ns/1ps
module flash_erase_ctrl_test;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          erase_req = 1'b0;
  logic [AW-1:0] blk_addr = '0;
  logic          susp_req = 1'b0;
  logic          res_req = 1'b0;
  logic [7:0]    fl_status = 8'h80;
  logic          fl_wr, fl_rd, busy, susp, done;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_data;
  logic [2:0]    err;

  always #2 clk = ~clk;

  flash_erase_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .erase_req_i(erase_req), .blk_addr_i(blk_addr),
    .suspend_req_i(susp_req), .resume_req_i(res_req), .flash_status_i(fl_status),
    .flash_wr_o(fl_wr), .flash_rd_o(fl_rd), .flash_addr_o(fl_addr), .flash_data_o(fl_data),
    .busy_o(busy), .susp_o(susp), .done_o(done), .err_o(err)
  );

  int checks = 0;
  int errors = 0;

  // flash device model
  int        erase_lat = 10;
  int        susp_lat  = 3;
  int        fail_pat [0:7];
  int        att_base  = 0;
  int        attempt   = 0;
  int        log_n     = 0;
  logic [7:0] log_mem [0:2047];
  logic [AW-1:0] exp_addr = '0;
  int        addr_bad  = 0;
  bit        m_erasing, m_armed, m_pend, m_susp;
  int        m_cnt, m_scnt;
  logic [7:0] sr_v;

  always @(posedge clk) begin
    if (!rst_n) begin
      sr_v = 8'h80; m_erasing = 0; m_armed = 0; m_pend = 0; m_susp = 0;
      m_cnt = 0; m_scnt = 0;
    end else begin
      if (m_erasing && !m_pend && !m_susp && erase_lat != 0) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          int idx;
          idx = attempt - att_base;
          if (idx > 7) idx = 7;
          m_erasing = 0;
          sr_v = 8'h80 | 8'(fail_pat[idx]);
          attempt = attempt + 1;
        end
      end
      if (m_pend && susp_lat != 0) begin
        m_scnt = m_scnt - 1;
        if (m_scnt == 0) begin m_pend = 0; m_susp = 1; sr_v[7] = 1'b1; end
      end
      if (fl_wr) begin
        log_mem[log_n & 2047] = fl_data;
        log_n = log_n + 1;
        if (fl_addr != exp_addr) addr_bad = addr_bad + 1;
        case (fl_data)
          8'h50: sr_v = sr_v & ~8'h3E;
          8'h20: m_armed = 1;
          8'hD0: begin
            if (m_armed) begin
              m_armed = 0; m_erasing = 1; m_cnt = erase_lat; sr_v[7] = 1'b0;
            end else if (m_susp) begin
              m_susp = 0; sr_v[7] = 1'b0;
            end else if (m_pend) m_pend = 0;
          end
          8'hB0: if (m_erasing) begin m_pend = 1; m_scnt = susp_lat; end
          default: ;
        endcase
      end
    end
    fl_status <= sr_v;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_code(input int s);
    if ((s & 8'h30) == 8'h30) return 1;
    if ((s & 8'h02) != 0)     return 2;
    if ((s & 8'h08) != 0)     return 3;
    if ((s & 8'h20) != 0)     return 4;
    return 0;
  endfunction

  function automatic int count_op(input int from, input logic [7:0] op);
    int c = 0;
    for (int i = from; i < log_n; i++) if (log_mem[i & 2047] == op) c++;
    return c;
  endfunction

  task automatic start_erase(input logic [AW-1:0] a);
    @(negedge clk);
    exp_addr  = a;
    att_base  = attempt;
    blk_addr  = a;
    erase_req = 1'b1;
    @(negedge clk);
    erase_req = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
  endtask

  task automatic final_report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    final_report();
  end

  initial begin
    int cyc, base, s, attempts, ec;
    for (int i = 0; i < 8; i++) fail_pat[i] = 0;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 susp", susp, 0);
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);
    chk("R1 wr/rd", fl_wr | fl_rd, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R8 R10 requests while idle are ignored
    base = log_n;
    susp_req = 1'b1; res_req = 1'b1;
    repeat (2) @(negedge clk);
    susp_req = 1'b0; res_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 idle suspend no writes", log_n - base, 0);
    chk("R10 idle resume busy", busy, 0);
    chk("R8 idle susp_o", susp, 0);

    // R4 R5 R6 sweep of error bit combinations
    erase_lat = 10; susp_lat = 3;
    for (int m = 0; m < 16; m++) begin
      s = ((m & 1) ? 8'h02 : 0) | ((m & 2) ? 8'h08 : 0) |
          ((m & 4) ? 8'h10 : 0) | ((m & 8) ? 8'h20 : 0);
      for (int i = 0; i < 8; i++) fail_pat[i] = s;
      ec = exp_code(s);
      attempts = (ec == 4) ? 4 : 1;
      base = log_n;
      start_erase(16'h1000 + 16'(m * 16'h0100));
      wait_done(cyc);
      chk($sformatf("R5 code status=%02h", s), err, ec);
      chk($sformatf("R6 attempts status=%02h", s), count_op(base, 8'h20), attempts);
      chk($sformatf("R4 write count status=%02h", s), log_n - base,
          attempts * (4 + (((s & 8'h3A) != 0) ? 2 : 0)));
      chk($sformatf("R4 last write status=%02h", s), log_mem[(log_n - 1) & 2047], 8'h70);
      @(negedge clk);
      chk("R11 done single cycle", done, 0);
      repeat (3) @(negedge clk);
      chk("R11 err held", err, ec);
    end
    chk("R2 address on every write", addr_bad, 0);

    // R6 retry then success
    fail_pat[0] = 8'h20; fail_pat[1] = 8'h20;
    for (int i = 2; i < 8; i++) fail_pat[i] = 0;
    base = log_n;
    start_erase(16'h2200);
    wait_done(cyc);
    chk("R6 retry success code", err, 0);
    chk("R6 retry attempts", count_op(base, 8'h20), 3);
    chk("R6 retry writes", log_n - base, 16);
    for (int i = 0; i < 8; i++) fail_pat[i] = 0;

    // R8 R10 suspend and resume, R2 request while busy
    erase_lat = 10; susp_lat = 3;
    base = log_n;
    start_erase(16'h3300);
    repeat (3) @(negedge clk);
    chk("R3 polling read", fl_rd, 1);
    susp_req = 1'b1;
    cyc = 0;
    while (!susp && cyc < 40) begin @(negedge clk); cyc++; end
    susp_req = 1'b0;
    chk("R8 suspended", susp, 1);
    chk("R8 suspend writes", log_n - base, 5);
    chk("R8 suspend opcode", log_mem[(base + 3) & 2047], 8'hB0);
    erase_req = 1'b1; blk_addr = 16'h7700;
    @(negedge clk);
    erase_req = 1'b0;
    ec = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (done || !susp) ec++;
    end
    chk("R8 stays suspended past erase timeout", ec, 0);
    res_req = 1'b1;
    @(negedge clk);
    res_req = 1'b0;
    wait_done(cyc);
    chk("R10 resumed code", err, 0);
    chk("R10 resume opcode", log_mem[(base + 5) & 2047], 8'hD0);
    chk("R10 total writes", log_n - base, 8);
    chk("R2 busy request ignored", count_op(base, 8'h20), 1);
    chk("R2 address kept", addr_bad, 0);

    // R9 suspend not acknowledged
    susp_lat = 0;
    base = log_n;
    start_erase(16'h4400);
    repeat (3) @(negedge clk);
    susp_req = 1'b1;
    cyc = 0;
    while (err != 3'd6 && cyc < 60) begin @(negedge clk); cyc++; end
    susp_req = 1'b0;
    chk("R9 early error code", err, 6);
    chk("R9 still busy", busy, 1);
    wait_done(cyc);
    chk("R9 final code", err, 6);
    chk("R9 write count", log_n - base, 8);
    chk("R9 undo opcode", log_mem[(base + 5) & 2047], 8'hD0);
    susp_lat = 3;

    // R7 erase never completes
    erase_lat = 0;
    start_erase(16'h5500);
    wait_done(cyc);
    chk("R7 timeout code", err, 5);
    chk("R7 timeout window", (cyc >= 80 && cyc <= 100) ? 1 : 0, 1);
    repeat (3) @(negedge clk);
    chk("R1 idle after timeout", busy | fl_wr | fl_rd, 0);

    final_report();
  end

endmodule